// File: doc/BRIEF.md
# Dual-Core Level Interrupt Fan-Out Controller

This block gathers 32 level-sensitive, active-high interrupt sources and routes each one to two processor cores. There are four outputs in total: an ordinary interrupt line and a machine-check line for each core. Each output has its own 32-bit enable word, so software can steer any source to any combination of the four outputs. Nothing arbitrates between the targets, so one source may drive every output at once.

A source stays pending for as long as its level is high. No register acknowledges or clears it, and the interrupt goes away only when the device lowers its request. Software reads the synchronised input levels from a read-only status word. It can also read a helper word that holds the highest-numbered source that is both pending and enabled for core 0's interrupt line, which is the source a handler services first. Access goes through a simple 32-bit register port. A write takes one strobe cycle and a read returns its data one cycle after the strobe.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: The status word at byte address 0x00 shows input n in bit n. Each input passes through two synchronising flops, so a level applied before clock edge k appears in status from edge k+2.
- R2: The four enable words are readable and writable at 0x10 (core 0 interrupt), 0x14 (core 1 interrupt), 0x18 (core 0 machine check) and 0x1C (core 1 machine check). A 1 in bit n enables source n for that output.
- R3: After reset all four enable words read zero and all four outputs are low.
- R4: Each output is a register that holds the OR of (status AND its enable word). It changes on the clock edge after the status or enable change that causes it.
- R5: A single source enabled in several enable words asserts every corresponding output at the same time, with no arbitration between them.
- R6: No write clears a pending source. An output stays high while its source is high and enabled, and falls only after the source goes low.
- R7: The word at 0x20 holds, in bits 4:0, the index of the highest-numbered bit set in (status AND core-0 interrupt enable), and a valid flag in bit 31. When no such bit is set, the whole word reads zero.
- R8: Writes to 0x00, 0x20, any unmapped address or any address with bits 1:0 not zero change no state. Reads of unmapped or misaligned addresses return zero.
- R9: A read strobe sampled on clock edge k presents the addressed word on the read data port from edge k on, and that value holds until the next read strobe.
- R10: A change on an input reaches an enabled output three clock edges after it is first sampled: two synchroniser edges and one output register edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Level-sensitive interrupt requests, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data follows one cycle later |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_irq | output | 2 | Interrupt line for each core |
| core_mchk | output | 2 | Machine-check line for each core |

## Verification
The hardest situation to reach from the ports is the one where a single source feeds all four outputs at once while a different source feeds only one output. Only this shows that the four targets are truly independent and do not share or steer a source. The stimulus loads four enable words that overlap on some bits and differ on others. It raises and lowers sources one at a time and checks every output three edges after each change. The priority readout gets the same treatment: the enable word is chosen to hide the highest pending source, so the reported index has to fall to the next one down.

// File: rtl/irq_fanout_pkg.sv
package irq_fanout_pkg;

  // Word indices (byte address divided by four) of the register port.
  localparam int unsigned WIDX_STATUS     = 0;
  localparam int unsigned WIDX_FIRST_MASK = 4;   // four enable words follow
  localparam int unsigned WIDX_TOP_INDEX  = 8;

  // Target numbering inside the block.
  localparam int unsigned NUM_TARGETS = 4;
  localparam int unsigned TGT_IRQ0    = 0;
  localparam int unsigned TGT_IRQ1    = 1;
  localparam int unsigned TGT_MCHK0   = 2;
  localparam int unsigned TGT_MCHK1   = 3;

endpackage

// File: rtl/irq_sync_stage.sv
module irq_sync_stage #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = async_in;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_fanout_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WORD_W  = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic                               wr_aligned,
  input  logic [WORD_W-1:0]                  wr_word,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_TARGETS-1:0][NUM_SRC-1:0] masks
);

  genvar t;
  generate
    for (t = 0; t < NUM_TARGETS; t++) begin : g_mask
      logic               hit;
      logic [NUM_SRC-1:0] mask_d;
      logic [NUM_SRC-1:0] mask_q;

      always_comb begin
        hit    = wr_en && wr_aligned && (wr_word == WORD_W'(WIDX_FIRST_MASK + t));
        mask_d = mask_q;
        if (hit) mask_d = wr_data[NUM_SRC-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
      end

      assign masks[t] = mask_q;
    end
  endgenerate

endmodule

// File: rtl/irq_top_finder.sv
module irq_top_finder #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] hot,
  output logic [IDX_W-1:0]   top_idx,
  output logic               top_valid
);

  // Scan upward; a later (higher) set bit overrides an earlier one.
  always_comb begin
    top_idx   = '0;
    top_valid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hot[i]) begin
        top_idx   = IDX_W'(i);
        top_valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_target_gate.sv
module irq_target_gate #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] enable,
  output logic               line_out
);

  logic line_d;
  logic line_q;

  always_comb line_d = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign line_out = line_q;

endmodule

// File: rtl/irq_fanout_ctrl.sv
module irq_fanout_ctrl
  import irq_fanout_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [1:0]          core_irq,
  output logic [1:0]          core_mchk
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = $clog2(NUM_SRC);
  localparam int unsigned PAD_W  = DATA_W - 1 - IDX_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // Address split.
  logic [WORD_W-1:0] word_sel;
  logic              aligned;
  assign word_sel = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);

  // Input synchroniser feeding the status word.
  logic [NUM_SRC-1:0] status_q;

  irq_sync_stage #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .async_in (irq_in),
    .sync_out (status_q)
  );

  // Enable words.
  logic [NUM_TARGETS-1:0][NUM_SRC-1:0] masks;

  irq_mask_bank #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .WORD_W  (WORD_W)
  ) u_masks (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (bus_wr),
    .wr_aligned (aligned),
    .wr_word    (word_sel),
    .wr_data    (bus_wdata),
    .masks      (masks)
  );

  // Output lines, one gate per target.
  logic [NUM_TARGETS-1:0] tgt_line;

  genvar t;
  generate
    for (t = 0; t < NUM_TARGETS; t++) begin : g_tgt
      irq_target_gate #(
        .NUM_SRC (NUM_SRC)
      ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n_s),
        .status   (status_q),
        .enable   (masks[t]),
        .line_out (tgt_line[t])
      );
    end
  endgenerate

  assign core_irq  = {tgt_line[TGT_IRQ1],  tgt_line[TGT_IRQ0]};
  assign core_mchk = {tgt_line[TGT_MCHK1], tgt_line[TGT_MCHK0]};

  // Highest pending source on core 0's interrupt line.
  logic [IDX_W-1:0] top_idx;
  logic             top_valid;

  irq_top_finder #(
    .NUM_SRC (NUM_SRC)
  ) u_finder (
    .hot       (status_q & masks[TGT_IRQ0]),
    .top_idx   (top_idx),
    .top_valid (top_valid)
  );

  // Read path: next-state mux and registered data with read enable.
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rdata_d = '0;
    if (aligned) begin
      if (word_sel == WORD_W'(WIDX_STATUS))
        rdata_d = DATA_W'(status_q);
      else if (word_sel == WORD_W'(WIDX_FIRST_MASK + TGT_IRQ0))
        rdata_d = DATA_W'(masks[TGT_IRQ0]);
      else if (word_sel == WORD_W'(WIDX_FIRST_MASK + TGT_IRQ1))
        rdata_d = DATA_W'(masks[TGT_IRQ1]);
      else if (word_sel == WORD_W'(WIDX_FIRST_MASK + TGT_MCHK0))
        rdata_d = DATA_W'(masks[TGT_MCHK0]);
      else if (word_sel == WORD_W'(WIDX_FIRST_MASK + TGT_MCHK1))
        rdata_d = DATA_W'(masks[TGT_MCHK1]);
      else if (word_sel == WORD_W'(WIDX_TOP_INDEX))
        rdata_d = top_valid ? {1'b1, {PAD_W{1'b0}}, top_idx} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_fanout_chk.sv
module irq_fanout_chk
  import irq_fanout_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input logic                               clk,
  input logic                               rst_n_s,
  input logic [NUM_SRC-1:0]                 irq_in,
  input logic [NUM_SRC-1:0]                 status_q,
  input logic [NUM_TARGETS-1:0][NUM_SRC-1:0] masks,
  input logic [NUM_TARGETS-1:0]             tgt_line,
  input logic [IDX_W-1:0]                   top_idx,
  input logic                               top_valid,
  input logic                               bus_wr,
  input logic [ADDR_W-1:0]                  bus_addr,
  input logic [DATA_W-1:0]                  bus_wdata
);

  logic [1:0] up_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)          up_q <= '0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end

  logic [NUM_SRC-1:0] hot;
  logic               mask_addr;
  assign hot       = status_q & masks[TGT_IRQ0];
  assign mask_addr = (bus_addr[1:0] == 2'b00) &&
                     (bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(WIDX_FIRST_MASK)) &&
                     (bus_addr[ADDR_W-1:2] <  (ADDR_W-2)'(WIDX_FIRST_MASK + NUM_TARGETS));

  // R1
  status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (up_q == 2'd3) |-> (status_q == $past(irq_in, 2)));

  // R2
  mask0_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == ADDR_W'(8'h10)) |=> (masks[TGT_IRQ0] == $past(bus_wdata[NUM_SRC-1:0])));

  genvar t;
  generate
    for (t = 0; t < NUM_TARGETS; t++) begin : g_line
      // R4
      line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        (|(status_q & masks[t])) |=> tgt_line[t]);
      // R4
      line_fall_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        !(|(status_q & masks[t])) |=> !tgt_line[t]);
    end
  endgenerate

  // R7
  top_pick_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    top_valid |-> (hot[top_idx] && ((hot >> top_idx) >> 1) == '0));

  // R7
  top_empty_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !top_valid |-> (hot == '0));

  // R8
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && !mask_addr) |=> $stable(masks));

endmodule

bind irq_fanout_ctrl irq_fanout_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .irq_in    (irq_in),
  .status_q  (status_q),
  .masks     (masks),
  .tgt_line  (tgt_line),
  .top_idx   (top_idx),
  .top_valid (top_valid),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_irq_fanout_ctrl.sv
module tb_irq_fanout_ctrl;

  localparam time PERIOD = 8ns;

  logic        clk;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  core_irq;
  logic [1:0]  core_mchk;

  int checks = 0;
  int fails  = 0;

  irq_fanout_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .core_irq  (core_irq),
    .core_mchk (core_mchk)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] outs();
    return {28'd0, core_mchk, core_irq};
  endfunction

  task automatic set_masks(input logic [31:0] m0, m1, m2, m3);
    bus_write(8'h10, m0); bus_write(8'h14, m1);
    bus_write(8'h18, m2); bus_write(8'h1C, m3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R3 outputs after reset", outs(), 32'd0);
    bus_read(8'h10, d); check("R3 mask irq0", d, 32'd0);
    bus_read(8'h14, d); check("R3 mask irq1", d, 32'd0);
    bus_read(8'h18, d); check("R3 mask mchk0", d, 32'd0);
    bus_read(8'h1C, d); check("R3 mask mchk1", d, 32'd0);
    bus_read(8'h20, d); check("R7 empty readout", d, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    irq_in = 32'hA5A5_0F0F; cycles(1);
    bus_read(8'h00, d); check("R1 status one edge", d, 32'd0);
    bus_read(8'h00, d); check("R1 status pattern A", d, 32'hA5A5_0F0F);
    irq_in = 32'h8000_0001; cycles(2);
    bus_read(8'h00, d); check("R1 status pattern B", d, 32'h8000_0001);
    check("R3 outputs stay low with masks clear", outs(), 32'd0);
    irq_in = 32'd0; cycles(3);
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    set_masks(32'h1111_0001, 32'h2222_0002, 32'h4444_0004, 32'h8888_0008);
    bus_read(8'h10, d); check("R2 irq0 mask", d, 32'h1111_0001);
    bus_read(8'h14, d); check("R2 irq1 mask", d, 32'h2222_0002);
    bus_read(8'h18, d); check("R2 mchk0 mask", d, 32'h4444_0004);
    bus_read(8'h1C, d); check("R2 mchk1 mask", d, 32'h8888_0008);
    set_masks(32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_latency();
    set_masks(32'h0000_0020, 32'd0, 32'd0, 32'd0);
    irq_in = 32'h0000_0020;
    cycles(2); check("R10 not yet after two edges", outs(), 32'd0);
    cycles(1); check("R10 irq0 after three edges", outs(), 32'h1);
    bus_write(8'h10, 32'd0);
    check("R4 old value before output edge", outs(), 32'h1);
    cycles(1); check("R4 cleared by mask one edge later", outs(), 32'h0);
    bus_write(8'h14, 32'h0000_0020);
    cycles(1); check("R4 irq1 from mask write", outs(), 32'h2);
    irq_in = 32'd0; cycles(3);
    check("R4 falls with input", outs(), 32'h0);
    set_masks(32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_fanout();
    set_masks(32'h0000_0080, 32'h0000_0088, 32'h0000_0080, 32'h0000_0080);
    irq_in = 32'h0000_0080; cycles(3);
    check("R5 one source drives all four", outs(), 32'hF);
    irq_in = 32'h0000_0008; cycles(3);
    check("R5 source only in irq1 mask", outs(), 32'h2);
    irq_in = 32'h0000_0088; cycles(3);
    check("R5 mixed sources", outs(), 32'hF);
    irq_in = 32'd0; cycles(3);
    set_masks(32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_masks(32'h0000_0400, 32'd0, 32'h0000_0400, 32'd0);
    irq_in = 32'h0000_0400; cycles(3);
    bus_write(8'h00, 32'd0);
    bus_write(8'h00, 32'hFFFF_FFFF);
    cycles(2);
    check("R6 output stays after status writes", outs(), 32'h5);
    bus_read(8'h00, d); check("R6 status unchanged by writes", d, 32'h0000_0400);
    irq_in = 32'd0; cycles(2);
    check("R6 still high before deassert reaches output", outs(), 32'h5);
    cycles(1); check("R6 drops after source low", outs(), 32'h0);
    set_masks(32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_topidx();
    logic [31:0] d;
    bus_write(8'h10, 32'hFFFF_FFFF);
    irq_in = 32'h8000_0004; cycles(2);
    bus_read(8'h20, d); check("R7 highest is 31", d, 32'h8000_001F);
    irq_in = 32'h0000_0001; cycles(2);
    bus_read(8'h20, d); check("R7 index zero valid", d, 32'h8000_0000);
    bus_write(8'h10, 32'h7FFF_FFFF);
    irq_in = 32'h8000_1004; cycles(2);
    bus_read(8'h20, d); check("R7 masked 31 falls to 12", d, 32'h8000_000C);
    irq_in = 32'd0; cycles(2);
    bus_read(8'h20, d); check("R7 nothing pending", d, 32'd0);
    bus_write(8'h10, 32'd0);
    cycles(2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    set_masks(32'h0000_00F0, 32'h0000_0F00, 32'h0000_F000, 32'h000F_0000);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_write(8'h11, 32'hFFFF_FFFF);
    bus_write(8'h1E, 32'hFFFF_FFFF);
    bus_read(8'h10, d); check("R8 irq0 mask untouched", d, 32'h0000_00F0);
    bus_read(8'h14, d); check("R8 irq1 mask untouched", d, 32'h0000_0F00);
    bus_read(8'h18, d); check("R8 mchk0 mask untouched", d, 32'h0000_F000);
    bus_read(8'h1C, d); check("R8 mchk1 mask untouched", d, 32'h000F_0000);
    bus_read(8'h04, d); check("R8 unmapped read 0x04", d, 32'd0);
    bus_read(8'h3C, d); check("R8 unmapped read 0x3C", d, 32'd0);
    bus_read(8'h11, d); check("R8 misaligned read", d, 32'd0);
    set_masks(32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_read_hold();
    logic [31:0] d;
    irq_in = 32'h1234_5678; cycles(2);
    bus_read(8'h00, d); check("R9 read data one edge after strobe", d, 32'h1234_5678);
    irq_in = 32'h0000_0000; cycles(4);
    check("R9 read data holds without strobe", bus_rdata, 32'h1234_5678);
    bus_read(8'h00, d); check("R9 new strobe refreshes", d, 32'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_status();
    t_mask_rw();
    t_latency();
    t_fanout();
    t_level();
    t_topidx();
    t_unmapped();
    t_read_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule